// File: doc/BRIEF.md
# Asynchronous Memory Wait Guard

This block supervises one access at a time to an external asynchronous memory whose cycle the device can stretch with a wait input. When an access is accepted, the block latches the target chip select, the byte address and a programmable limit on wait cycles. It then counts the cycles in which the synchronized wait input is asserted. The access ends with a one-cycle acknowledge once wait is released and a minimum strobe length has passed. If wait holds the cycle for longer than the limit, the access ends with a one-cycle error instead. A sticky interrupt is raised and the failing byte address is kept until software clears both with a write-one-to-clear strobe.

The block also forms the address driven on the external address lines. It can run in shift mode, which an enable bit selects. In shift mode the byte address is shifted right by the data width configured for the selected chip select, so a wider device covers a larger byte range on the same pins. With the default 24 external address lines, a 32-bit device spans 64 MB per chip select. The wait limit should be set to at least five times the worst-case delay of the external wait signal. A limit close to that delay can raise timeouts on devices that are working correctly.

Top module: `amw_wait_guard`

## Requirements
- R1: While rst_ni is low, and afterwards until the first access, the block shows the following values: busy_o, ack_o, err_o and irq_o low, cs_n_o all ones, ext_addr_o zero and fail_addr_o zero.
- R2: A req_i sampled high while idle starts an access. From the next cycle busy_o is high and only bit cs_i of the active-low cs_n_o is low. A req_i sampled while busy is ignored, and no access starts after the current one ends.
- R3: ext_wait_i passes through a two-stage synchronizer. A wait released after rising edge D of an access is first seen low at rising edge D+3.
- R4: With wait low, an access ends at the first edge where the synchronized wait is low and at least 3 edges have passed since acceptance. With wait never asserted, ack_o is high for exactly one cycle after the 4th edge following acceptance, and busy_o drops in that cycle.
- R5: The wait limit max_wait_i is latched at acceptance. When the synchronized wait has been sampled high on max_wait_i+1 edges of one access, the access ends with a one-cycle err_o and no ack_o. A limit of 0 times out on the first high sample.
- R6: A timeout sets irq_o and loads fail_addr_o with the byte address of the failing access. Both hold their values until cleared.
- R7: clr_i sampled high clears irq_o and sets fail_addr_o to zero. If a timeout occurs at the same edge, the timeout wins.
- R8: With shift_en_i low, ext_addr_o equals addr_i[23:0] latched at acceptance.
- R9: With shift_en_i high, ext_addr_o equals (addr_i >> s)[23:0]. Here s comes from the 2-bit width code at width_cfg_i[2k+1:2k] for chip select k: 00 (8-bit) gives s=0, 01 (16-bit) gives s=1, and 10 (32-bit) and 11 (reserved) give s=2.
- R10: During an access, ext_addr_o, cs_n_o and the wait limit do not change. Changes to addr_i, cs_i, width_cfg_i, shift_en_i and max_wait_i in that time have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access when idle |
| addr_i | input | 32 | Byte address of the access |
| cs_i | input | 2 | Chip select index |
| width_cfg_i | input | 8 | Data width code per chip select, 2 bits each |
| shift_en_i | input | 1 | Enable address shifting by data width |
| max_wait_i | input | 8 | Wait-cycle limit, latched at acceptance |
| ext_wait_i | input | 1 | Asynchronous wait input from the device |
| clr_i | input | 1 | Write-one-to-clear for interrupt and captured address |
| busy_o | output | 1 | Access in progress |
| cs_n_o | output | 4 | Active-low chip selects |
| ext_addr_o | output | 24 | External address lines |
| ack_o | output | 1 | One-cycle normal completion |
| err_o | output | 1 | One-cycle timeout termination |
| irq_o | output | 1 | Sticky timeout interrupt |
| fail_addr_o | output | 32 | Byte address of the last failing access |

## Verification
A wait counter that is off by one shows up as an err_o or ack_o pulse one edge too early or too late. The bench predicts the exact edge for every access, so this fault appears at the end of the first access that is affected. A synchronizer of the wrong depth shifts the acknowledge edge when wait is released early, and the directed short-wait cases detect it. Addresses latched at the wrong time, or shift amounts mapped wrongly, show on ext_addr_o in the first cycle after acceptance, because the inputs are scrambled during the access. A corrupted sticky state shows at irq_o or fail_addr_o, which the bench compares on every cycle.

// File: rtl/amw_pkg.sv
package amw_pkg;
  typedef enum logic [1:0] {
    BUS_W8   = 2'b00,
    BUS_W16  = 2'b01,
    BUS_W32  = 2'b10,
    BUS_WRSV = 2'b11
  } bus_width_e;

  // right shift that turns a byte address into a device word address
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    logic [1:0] s;
    case (bus_width_e'(code))
      BUS_W8:  s = 2'd0;
      BUS_W16: s = 2'd1;
      default: s = 2'd2;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/amw_sync.sv
module amw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/amw_addr_xlate.sv
module amw_addr_xlate import amw_pkg::*; #(
  parameter int AW  = 32,
  parameter int EAW = 24,
  parameter int NCS = 4,
  parameter int CSW = 2
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [CSW-1:0]   cs_i,
  input  logic [2*NCS-1:0] width_cfg_i,
  input  logic             shift_en_i,
  output logic [EAW-1:0]   ext_addr_o
);
  logic [EAW-1:0] cand [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic [1:0]    sh;
    logic [AW-1:0] shifted;
    assign sh      = shift_en_i ? width_shift(width_cfg_i[2*g +: 2]) : 2'd0;
    assign shifted = addr_i >> sh;
    assign cand[g] = shifted[EAW-1:0];
  end

  assign ext_addr_o = cand[cs_i];
endmodule

// File: rtl/amw_wait_ctrl.sv
module amw_wait_ctrl #(
  parameter int AW      = 32,
  parameter int EAW     = 24,
  parameter int NCS     = 4,
  parameter int CSW     = 2,
  parameter int CW      = 8,
  parameter int MIN_CYC = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           wait_s_i,
  input  logic [CW-1:0]  max_wait_i,
  input  logic           clr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CSW-1:0] cs_i,
  input  logic [EAW-1:0] ext_addr_d_i,
  output logic           busy_o,
  output logic [NCS-1:0] cs_n_o,
  output logic [EAW-1:0] ext_addr_o,
  output logic           ack_o,
  output logic           err_o,
  output logic           irq_o,
  output logic [AW-1:0]  fail_addr_o
);
  localparam int             EW    = $clog2(MIN_CYC + 1);
  localparam logic [EW-1:0]  MIN_L = EW'(MIN_CYC);

  logic           busy_q, ack_q, err_q, irq_q;
  logic [CW-1:0]  wcnt_q, maxw_q;
  logic [EW-1:0]  elap_q;
  logic [AW-1:0]  addr_q, fail_q;
  logic [CSW-1:0] cs_q;
  logic [EAW-1:0] ext_q;
  logic           start, to_hit, fin_ok;

  assign start  = req_i & ~busy_q;
  // wcnt never passes maxw: equality ends the access
  assign to_hit = busy_q & wait_s_i & (wcnt_q == maxw_q);
  assign fin_ok = busy_q & ~wait_s_i & (elap_q >= MIN_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      wcnt_q <= '0;
      maxw_q <= '0;
      elap_q <= '0;
      addr_q <= '0;
      cs_q   <= '0;
      ext_q  <= '0;
    end else begin
      ack_q <= fin_ok;
      err_q <= to_hit;
      if (start) begin
        busy_q <= 1'b1;
        wcnt_q <= '0;
        elap_q <= '0;
        maxw_q <= max_wait_i;
        addr_q <= addr_i;
        cs_q   <= cs_i;
        ext_q  <= ext_addr_d_i;
      end else if (to_hit || fin_ok) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (elap_q != MIN_L) elap_q <= elap_q + 1'b1;
        if (wait_s_i)        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      fail_q <= '0;
    end else if (to_hit) begin
      irq_q  <= 1'b1;
      fail_q <= addr_q;
    end else if (clr_i) begin
      irq_q  <= 1'b0;
      fail_q <= '0;
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_csn
    assign cs_n_o[g] = ~(busy_q && (cs_q == CSW'(g)));
  end

  assign busy_o      = busy_q;
  assign ext_addr_o  = ext_q;
  assign ack_o       = ack_q;
  assign err_o       = err_q;
  assign irq_o       = irq_q;
  assign fail_addr_o = fail_q;
endmodule

// File: rtl/amw_wait_guard.sv
module amw_wait_guard #(
  parameter int AW      = 32,
  parameter int EAW     = 24,
  parameter int NCS     = 4,
  parameter int CSW     = $clog2(NCS),
  parameter int CW      = 8,
  parameter int MIN_CYC = 3,
  parameter int SYNC_ST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CSW-1:0]   cs_i,
  input  logic [2*NCS-1:0] width_cfg_i,
  input  logic             shift_en_i,
  input  logic [CW-1:0]    max_wait_i,
  input  logic             ext_wait_i,
  input  logic             clr_i,
  output logic             busy_o,
  output logic [NCS-1:0]   cs_n_o,
  output logic [EAW-1:0]   ext_addr_o,
  output logic             ack_o,
  output logic             err_o,
  output logic             irq_o,
  output logic [AW-1:0]    fail_addr_o
);
  logic           wait_s;
  logic [EAW-1:0] ext_addr_d;

  amw_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_wait_i),
    .q_o   (wait_s)
  );

  amw_addr_xlate #(.AW(AW), .EAW(EAW), .NCS(NCS), .CSW(CSW)) u_xlate (
    .addr_i     (addr_i),
    .cs_i       (cs_i),
    .width_cfg_i(width_cfg_i),
    .shift_en_i (shift_en_i),
    .ext_addr_o (ext_addr_d)
  );

  amw_wait_ctrl #(
    .AW(AW), .EAW(EAW), .NCS(NCS), .CSW(CSW), .CW(CW), .MIN_CYC(MIN_CYC)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .wait_s_i    (wait_s),
    .max_wait_i  (max_wait_i),
    .clr_i       (clr_i),
    .addr_i      (addr_i),
    .cs_i        (cs_i),
    .ext_addr_d_i(ext_addr_d),
    .busy_o      (busy_o),
    .cs_n_o      (cs_n_o),
    .ext_addr_o  (ext_addr_o),
    .ack_o       (ack_o),
    .err_o       (err_o),
    .irq_o       (irq_o),
    .fail_addr_o (fail_addr_o)
  );
endmodule

// File: rtl/amw_guard_chk.sv
module amw_guard_chk #(
  parameter int AW  = 32,
  parameter int EAW = 24,
  parameter int NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           clr_i,
  input logic           busy_i,
  input logic [NCS-1:0] cs_n_i,
  input logic [EAW-1:0] ext_addr_i,
  input logic           ack_i,
  input logic           err_i,
  input logic           irq_i,
  input logic [AW-1:0]  fail_addr_i
);
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (cs_n_i == '1)); // R2
  AST_ONE_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ($countones(~cs_n_i) == 1)); // R2
  AST_END_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && err_i)); // R5
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i || err_i) |-> !busy_i); // R4
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ack_i); // R4
  AST_ERR_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> irq_i); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !clr_i) |=> irq_i); // R7
  AST_CLR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!irq_i || err_i)); // R7
  AST_FAIL_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_i && !$past(clr_i)) |-> $stable(fail_addr_i)); // R6
  AST_EXT_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i ##1 busy_i |-> $stable(ext_addr_i)); // R10
endmodule

bind amw_wait_guard amw_guard_chk #(.AW(AW), .EAW(EAW), .NCS(NCS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .busy_i     (busy_o),
  .cs_n_i     (cs_n_o),
  .ext_addr_i (ext_addr_o),
  .ack_i      (ack_o),
  .err_i      (err_o),
  .irq_i      (irq_o),
  .fail_addr_i(fail_addr_o)
);

// File: tb/tb_amw_wait_guard.sv
module tb_amw_wait_guard;
  localparam int AW = 32, EAW = 24, NCS = 4, CSW = 2, CW = 8, MIN_CYC = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic [CSW-1:0]   cs_i = '0;
  logic [2*NCS-1:0] width_cfg_i = '0;
  logic             shift_en_i = 1'b0;
  logic [CW-1:0]    max_wait_i = '0;
  logic             ext_wait_i = 1'b0;
  logic             clr_i = 1'b0;
  logic             busy_o, ack_o, err_o, irq_o;
  logic [NCS-1:0]   cs_n_o;
  logic [EAW-1:0]   ext_addr_o;
  logic [AW-1:0]    fail_addr_o;

  int n_chk = 0, n_fail = 0;
  logic          irq_exp = 1'b0;
  logic [AW-1:0] fail_exp = '0;

  always #5 clk = ~clk;

  amw_wait_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .cs_i(cs_i),
    .width_cfg_i(width_cfg_i), .shift_en_i(shift_en_i), .max_wait_i(max_wait_i),
    .ext_wait_i(ext_wait_i), .clr_i(clr_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
    .ext_addr_o(ext_addr_o), .ack_o(ack_o), .err_o(err_o), .irq_o(irq_o),
    .fail_addr_o(fail_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [EAW-1:0] exp_ext(input logic [AW-1:0] a, input logic [CSW-1:0] c,
                                             input logic [2*NCS-1:0] w, input logic sh);
    logic [1:0] code;
    logic [AW-1:0] r;
    int s;
    code = w[2*c +: 2];
    s = (code == 2'b00) ? 0 : (code == 2'b01) ? 1 : 2;
    r = sh ? (a >> s) : a;
    return r[EAW-1:0];
  endfunction

  function automatic logic [NCS-1:0] exp_csn(input logic [CSW-1:0] c);
    logic [NCS-1:0] v;
    v = '1;
    v[c] = 1'b0;
    return v;
  endfunction

  // mode 0: wait low; 1: wait high, released after edge d; 2: wait high throughout
  task automatic run(input logic [AW-1:0] a, input logic [CSW-1:0] c, input logic [2*NCS-1:0] w,
                     input logic sh, input logic [CW-1:0] m, input int mode, input int d,
                     input int clr_k, input bit scramble);
    int kend;
    bit is_err;
    logic [EAW-1:0] ea;
    logic [NCS-1:0] ec;
    ext_wait_i = (mode != 0);
    repeat (3) @(negedge clk);
    addr_i = a; cs_i = c; width_cfg_i = w; shift_en_i = sh; max_wait_i = m; req_i = 1'b1;
    ea = exp_ext(a, c, w, sh);
    ec = exp_csn(c);
    if (mode == 0) begin
      is_err = 0; kend = MIN_CYC + 1;
    end else if (mode == 2 || (d + 2 >= int'(m) + 1)) begin
      is_err = 1; kend = int'(m) + 1;
    end else begin
      is_err = 0; kend = (d + 3 > MIN_CYC + 1) ? d + 3 : MIN_CYC + 1;
    end
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    if (scramble) begin
      addr_i = $urandom; cs_i = CSW'($urandom); width_cfg_i = 8'($urandom);
      shift_en_i = ~sh; max_wait_i = 8'($urandom);
      if (kend >= 2) req_i = 1'b1;  // R2: must be ignored while busy
    end
    chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
    chk(cs_n_o == ec, "R2 chip select", cs_n_o, ec);
    chk(ext_addr_o == ea, sh ? "R9 shifted address" : "R8 plain address", ext_addr_o, ea);
    for (int k = 1; k <= kend; k++) begin
      bit clr_now;
      clr_now = (clr_k == k);
      if (clr_now) clr_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr_i = 1'b0;
      if (k == 1) req_i = 1'b0;
      if (k == kend && is_err) begin
        irq_exp = 1'b1; fail_exp = a;
      end else if (clr_now) begin
        irq_exp = 1'b0; fail_exp = '0;
      end
      if (mode == 1 && k == d) ext_wait_i = 1'b0;
      if (k < kend) begin
        chk(busy_o && !ack_o && !err_o, "R4 access still running", {busy_o, ack_o, err_o}, 3'b100);
        chk(ext_addr_o == ea && cs_n_o == ec, "R10 address and select held",
            {cs_n_o, ext_addr_o}, {ec, ea});
      end else begin
        chk(!busy_o, "R4 busy drops at end", busy_o, 0);
        chk(ack_o == !is_err, "R4 ack edge", ack_o, !is_err);
        chk(err_o == is_err, "R5 timeout edge", err_o, is_err);
      end
      chk(irq_o == irq_exp, "R6 irq flag", irq_o, irq_exp);
      chk(fail_addr_o == fail_exp, "R6 captured address", fail_addr_o, fail_exp);
    end
    ext_wait_i = 1'b0;
    @(negedge clk);
    chk(!busy_o && !ack_o && !err_o, "R2 no restart after end", {busy_o, ack_o, err_o}, 0);
  endtask

  task automatic pulse_clr();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    irq_exp = 1'b0; fail_exp = '0;
    chk(!irq_o, "R7 clear irq", irq_o, 0);
    chk(fail_addr_o == '0, "R7 clear address", fail_addr_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk({busy_o, ack_o, err_o, irq_o} == 4'b0, "R1 flags in reset", {busy_o, ack_o, err_o, irq_o}, 0);
    chk(cs_n_o == '1, "R1 selects in reset", cs_n_o, 4'hf);
    chk(ext_addr_o == '0 && fail_addr_o == '0, "R1 addresses in reset", {ext_addr_o, fail_addr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && cs_n_o == '1 && !irq_o, "R1 idle after reset", {busy_o, cs_n_o, irq_o}, 5'b01110);

    run(32'h0012_3456, 2'd0, 8'h00, 1'b0, 8'd9, 0, 0, 0, 0);  // R4 R8
    run(32'h00AB_CDEF, 2'd1, 8'h00, 1'b0, 8'd0, 2, 0, 0, 0);  // R5 limit 0
    run(32'h0000_1000, 2'd2, 8'h00, 1'b0, 8'd9, 0, 0, 2, 0);  // R7 clear mid-access
    run(32'h0100_0040, 2'd3, 8'h00, 1'b0, 8'd6, 2, 0, 0, 0);  // R5 R6
    run(32'h0200_0080, 2'd0, 8'h00, 1'b0, 8'd4, 2, 0, 5, 0);  // R7 timeout beats clear
    pulse_clr();
    run(32'h03FF_FFFF, 2'd0, 8'b11_10_01_00, 1'b1, 8'd9, 0, 0, 0, 0);  // R9 8-bit
    run(32'h03FF_FFFF, 2'd1, 8'b11_10_01_00, 1'b1, 8'd9, 0, 0, 0, 0);  // R9 16-bit
    run(32'h03FF_FFFF, 2'd2, 8'b11_10_01_00, 1'b1, 8'd9, 0, 0, 0, 0);  // R9 32-bit
    run(32'h03FF_FFFC, 2'd3, 8'b11_10_01_00, 1'b1, 8'd9, 0, 0, 0, 0);  // R9 reserved
    run(32'h0155_5554, 2'd2, 8'b00_10_00_00, 1'b1, 8'd20, 1, 6, 0, 1); // R10 scrambled inputs
    run(32'h0000_0010, 2'd1, 8'h00, 1'b0, 8'd5, 1, 1, 0, 0);  // R3 ack at edge 4
    run(32'h0000_0020, 2'd1, 8'h00, 1'b0, 8'd10, 1, 3, 0, 0); // R3 ack at edge 6
    run(32'h0000_0030, 2'd0, 8'h00, 1'b0, 8'd4, 1, 2, 0, 0);  // R5 one short of limit
    run(32'h0000_0040, 2'd0, 8'h00, 1'b0, 8'd4, 1, 3, 0, 0);  // R5 exactly over limit

    for (int i = 0; i < 80; i++) begin
      int mode, d, ck;
      mode = $urandom_range(0, 2);
      d = $urandom_range(1, 25);
      ck = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
      run($urandom, CSW'($urandom), 8'($urandom), 1'($urandom), 8'($urandom_range(0, 20)),
          mode, d, ck, 1'($urandom));
      if ($urandom_range(0, 4) == 0) pulse_clr();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule